// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets synchronous logic use an external asynchronous static memory with a 19-bit address and an 8-bit data word. On the host side it accepts one request at a time through a valid/ready handshake. A request carries an address, a write flag and write data. For reads the block returns the data with a one-clock done strobe. On the memory side it drives active-low chip select, write enable and output enable, plus the address bus. The data bus is split into an output value, an output enable for the pad tristate, and the value read back from the pad.

Each memory phase lasts a whole number of clocks. Every count is the ceiling of a minimum nanosecond figure divided by `CLK_PERIOD_NS`, and is never less than one. A write is ended by write enable rising. Output enable stays high for the whole write. The host does not drive data until a release interval has passed since write enable fell. A read holds chip select and output enable low for the full access count, and the data is registered on the last clock of that phase.

The controller has six states: `ST_IDLE`, `ST_SETUP`, `ST_WR_TURN`, `ST_WR_DRIVE`, `ST_WR_RECOV` and `ST_RD_ACCESS`. The transitions are:

- `ST_IDLE` to `ST_SETUP` when a request is accepted.
- `ST_SETUP` to `ST_WR_TURN` for a write, or to `ST_RD_ACCESS` for a read.
- `ST_WR_TURN` to `ST_WR_DRIVE` to `ST_WR_RECOV` to `ST_IDLE`, each step taken when the phase timer expires.
- `ST_RD_ACCESS` to `ST_IDLE` when the phase timer expires.

Top module: `asram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and on the first clock after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: `req_ready` is 1 only in `ST_IDLE`. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle, including its recovery, has finished. The clock after acceptance (`ST_SETUP`) has all three strobes at 1.
- R3: In a write, `mem_we_n` is 0 for exactly N_TURN+N_WDRV clocks. With the defaults that is 12 clocks, which covers the 35 ns pulse, the 40 ns chip-select-to-end time and the 40 ns address-to-end time. `mem_oe_n` is 1 whenever `mem_we_n` is 0.
- R4: `mem_dq_oe` is 1 only while `mem_oe_n` is 1. During a write it rises only after `mem_we_n` has been 0 for N_TURN = ceil(20/period) clocks (5 clocks with the defaults).
- R5: The write data on `mem_dq_out` is driven and unchanged for at least ceil(25/period) clocks before `mem_we_n` rises. It is still driven, with the same value, on the clock in which `mem_we_n` rises.
- R6: A write ends with `mem_we_n` rising while `mem_cs_n` is still 0. Each cycle keeps `mem_cs_n` at 0 for at least ceil(55/period) clocks (14 with the defaults). For a write, `req_ready` returns 16 clocks after acceptance.
- R7: In a read, `mem_cs_n` and `mem_oe_n` are 0 and `mem_we_n` is 1 for exactly N_RD = ceil(55/period) clocks. `mem_dq_in` is registered at the clock edge that ends the last of those clocks.
- R8: `rsp_done` is 1 for exactly one clock, 16 clocks after the read was accepted with the defaults. It is never 1 after a write. `rsp_rdata` holds the last read value until the next read completes.
- R9: `mem_addr` takes the request address on acceptance and changes only while `mem_cs_n` is 1. Request inputs presented while no request is accepted have no effect.
- R10: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Last read data |
| rsp_done | output | 1 | One-clock read completion strobe |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 8 | Data value for the pad driver |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | 8 | Data seen on the pad |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest situation to create from the ports is a cycle that starts the moment the previous one ends. Examples are a write straight after a read, or two writes to one address with the request already waiting. Here the idle gap, the bus turnaround and the address hold are all at their minimum.

The stimulus keeps the next request ready at the clock where `req_ready` returns, and chooses addresses from a small pool so that repeats are frequent. A bench memory model returns a poison value until the full access count has passed, and records writes only at the rising write enable.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WR_TURN,
        ST_WR_DRIVE,
        ST_WR_RECOV,
        ST_RD_ACCESS
    } ctl_state_e;

    // Whole clocks needed to cover a nanosecond minimum, never below one.
    function automatic int clocks_for(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // The count parks at zero rather than wrapping (phase lengths R3, R7).
    assert_timer_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              cur_write,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done
);

    // Request fields are latched only on acceptance (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_write <= 1'b0;
        end else if (accept) begin
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            cur_write <= req_write;
        end
    end

    // Read data is registered on the last access clock (R7); done follows it (R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_done  <= 1'b0;
        end else begin
            rsp_done <= capture;
            if (capture) begin
                rsp_rdata <= mem_dq_in;
            end
        end
    end

endmodule

// File: rtl/asram_cycle_ctrl.sv
module asram_cycle_ctrl
    import asram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_RC_NS       = 55,
    parameter int T_AA_NS       = 55,
    parameter int T_OE_NS       = 25,
    parameter int T_WC_NS       = 55,
    parameter int T_WP_NS       = 35,
    parameter int T_CW_NS       = 40,
    parameter int T_AW_NS       = 40,
    parameter int T_DW_NS       = 25,
    parameter int T_REL_NS      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);

    // Phase lengths in clocks
    localparam int N_TURN  = clocks_for(T_REL_NS, CLK_PERIOD_NS);
    localparam int N_RD    = clocks_for(imax(T_RC_NS, imax(T_AA_NS, T_OE_NS)), CLK_PERIOD_NS);
    localparam int WE_MIN  = imax(clocks_for(T_WP_NS, CLK_PERIOD_NS),
                                  imax(clocks_for(T_CW_NS, CLK_PERIOD_NS),
                                       clocks_for(T_AW_NS, CLK_PERIOD_NS)));
    localparam int N_WDRV  = imax(clocks_for(T_DW_NS, CLK_PERIOD_NS), WE_MIN - N_TURN);
    localparam int N_WREC  = imax(1, clocks_for(T_WC_NS, CLK_PERIOD_NS) - N_TURN - N_WDRV);
    localparam int CNT_MAX = imax(N_RD, imax(N_TURN, imax(N_WDRV, N_WREC)));
    localparam int CNT_W   = imax(1, $clog2(CNT_MAX + 1));

    localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(N_TURN - 1);
    localparam logic [CNT_W-1:0] LD_WDRV = CNT_W'(N_WDRV - 1);
    localparam logic [CNT_W-1:0] LD_WREC = CNT_W'(N_WREC - 1);
    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(N_RD - 1);

    ctl_state_e       state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;
    logic             cur_write;
    logic [DATA_W-1:0] cur_wdata;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .mem_dq_in (mem_dq_in),
        .cur_addr  (mem_addr),
        .cur_wdata (cur_wdata),
        .cur_write (cur_write),
        .rsp_rdata (rsp_rdata),
        .rsp_done  (rsp_done)
    );

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign mem_dq_out = cur_wdata;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                if (cur_write) begin
                    state_d = ST_WR_TURN;
                    tmr_val = LD_TURN;
                end else begin
                    state_d = ST_RD_ACCESS;
                    tmr_val = LD_RD;
                end
            end
            ST_WR_TURN: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_DRIVE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WDRV;
                end
            end
            ST_WR_DRIVE: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WREC;
                end
            end
            ST_WR_RECOV: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                    capture = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobe decode
    always_comb begin
        req_ready = 1'b0;
        mem_cs_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_SETUP: begin
            end
            ST_WR_TURN: begin
                mem_cs_n = 1'b0;
                mem_we_n = 1'b0;
            end
            ST_WR_DRIVE: begin
                mem_cs_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_RECOV: begin
                mem_cs_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_RD_ACCESS: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

    // Assertions
    assert_oe_high_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_no_drive_when_mem_may_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

    assert_write_ends_on_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe));

    assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_addr_stable_cs_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> (mem_addr == $past(mem_addr)));

endmodule

// File: tb/asram_cycle_ctrl_bench.sv
module asram_cycle_ctrl_bench;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + 3) / 4;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_TURN = cyc(20);
    localparam int EXP_RD   = cyc(55);
    localparam int EXP_WE   = mx(cyc(35), mx(cyc(40), EXP_TURN + cyc(25)));
    localparam int EXP_WCS  = mx(cyc(55), EXP_WE + 1);
    localparam int EXP_WLAT = EXP_WCS + 2;
    localparam int EXP_RLAT = EXP_RD + 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [18:0] req_addr;
    logic [7:0]  req_wdata;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in;
    logic        mem_cs_n;
    logic        mem_we_n;
    logic        mem_oe_n;

    always #2 clk = ~clk;

    asram_cycle_ctrl u_asram_cycle_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_rdata  (rsp_rdata),
        .rsp_done   (rsp_done),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Memory model: poison value until the full access count has elapsed
    logic [7:0] mdl_mem [int];
    logic [7:0] exp_mem [int];
    int rd_cnt;
    logic rd_act;
    assign rd_act = !mem_cs_n && !mem_oe_n && mem_we_n;

    always @(posedge clk) begin
        if (!rst_n) rd_cnt <= 0;
        else        rd_cnt <= rd_act ? rd_cnt + 1 : 0;
    end

    always @* begin
        mem_dq_in = 8'hEE;
        if (rd_act && rd_cnt >= EXP_RD - 1) begin
            mem_dq_in = mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : 8'h00;
        end
    end

    // Port monitor, sampled mid-clock
    int   we_run, drv_run, cs_run, rd_run;
    logic p_we, p_cs, p_rd, p_oe_drv;
    logic [7:0]  p_dq;
    logic [18:0] p_addr;

    always @(negedge clk) begin
        if (!rst_n) begin
            we_run = 0; drv_run = 0; cs_run = 0; rd_run = 0;
            p_we = 1'b1; p_cs = 1'b1; p_rd = 1'b0; p_oe_drv = 1'b0;
            p_dq = '0; p_addr = '0;
        end else begin
            if (mem_dq_oe && !mem_oe_n) check(1'b0, "R4 drive while oe low", 1, 0);
            if (mem_dq_oe && !mem_we_n && we_run + 1 <= EXP_TURN)
                check(1'b0, "R4 drive inside release window", we_run + 1, EXP_TURN + 1);
            if (mem_dq_oe && p_oe_drv && mem_dq_out != p_dq)
                check(1'b0, "R5 data changed while driven", int'(mem_dq_out), int'(p_dq));
            if (!mem_we_n && !mem_oe_n) check(1'b0, "R3 oe low during write", 0, 1);
            if (!mem_cs_n && !p_cs && mem_addr != p_addr)
                check(1'b0, "R9 address moved with cs low", int'(mem_addr), int'(p_addr));
            if (mem_we_n && !p_we) begin
                check(!mem_cs_n, "R6 we rise with cs low", int'(mem_cs_n), 0);
                check(we_run == EXP_WE, "R3 we low length", we_run, EXP_WE);
                check(drv_run >= cyc(25), "R5 data setup", drv_run, cyc(25));
                check(mem_dq_oe && mem_dq_out == p_dq, "R5 data hold", int'(mem_dq_out), int'(p_dq));
                mdl_mem[int'(p_addr)] = p_dq;
            end
            if (!rd_act && p_rd) check(rd_run == EXP_RD, "R7 read phase length", rd_run, EXP_RD);
            if (mem_cs_n && !p_cs) check(cs_run >= cyc(55), "R6 cs low length", cs_run, cyc(55));
            we_run  = !mem_we_n ? we_run + 1 : 0;
            drv_run = mem_dq_oe ? drv_run + 1 : 0;
            cs_run  = !mem_cs_n ? cs_run + 1 : 0;
            rd_run  = rd_act ? rd_run + 1 : 0;
            p_we = mem_we_n; p_cs = mem_cs_n; p_rd = rd_act; p_oe_drv = mem_dq_oe;
            p_dq = mem_dq_out; p_addr = mem_addr;
        end
    end

    function automatic logic [7:0] expect_at(input logic [18:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
    endfunction

    // Issue one request; called at a negedge
    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
        int lat;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = ~wr;
        req_addr  = 19'($urandom);
        req_wdata = 8'($urandom);
        lat = 1;
        check(mem_cs_n && mem_we_n && mem_oe_n && !req_ready, "R2 setup clock idle", 
              int'({mem_cs_n, mem_we_n, mem_oe_n, req_ready}), 4'he);
        check(mem_addr == a, "R9 address latched", int'(mem_addr), int'(a));
        if (wr) begin
            exp_mem[int'(a)] = d;
            while (!req_ready && lat < 100) begin
                if (rsp_done) check(1'b0, "R8 done after write", 1, 0);
                @(negedge clk);
                lat++;
            end
            check(lat == EXP_WLAT, "R6 write ready return", lat, EXP_WLAT);
        end else begin
            while (!rsp_done && lat < 100) begin
                if (req_ready) check(1'b0, "R2 ready during read", 1, 0);
                @(negedge clk);
                lat++;
            end
            check(lat == EXP_RLAT, "R8 done timing", lat, EXP_RLAT);
            check(rsp_rdata == expect_at(a), "R10 read data", int'(rsp_rdata), int'(expect_at(a)));
            check(req_ready, "R2 ready with done", int'(req_ready), 1);
            @(negedge clk);
            check(!rsp_done, "R8 done one clock", int'(rsp_done), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes in reset",
              int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 4'he);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_done, "R1 ready after reset", int'({req_ready, rsp_done}), 2'b10);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes after reset",
              int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 4'he);

        // Inputs without valid are ignored (R9)
        req_addr = 19'h12345; req_wdata = 8'h77; req_write = 1'b1;
        repeat (4) @(negedge clk);
        check(mem_cs_n && mem_addr == 19'h0, "R9 no accept without valid", int'(mem_addr), 0);

        // Directed corners
        issue(1'b0, 19'h00000, 8'h00);
        issue(1'b1, 19'h7FFFF, 8'h5A);
        issue(1'b1, 19'h00000, 8'hA5);
        issue(1'b0, 19'h7FFFF, 8'h00);
        issue(1'b1, 19'h00000, 8'h3C);
        issue(1'b1, 19'h00000, 8'hC3);
        issue(1'b0, 19'h00000, 8'h00);
        held = rsp_rdata;
        issue(1'b1, 19'h00001, 8'hFF);
        check(rsp_rdata == held, "R8 rdata held over write", int'(rsp_rdata), int'(held));
        issue(1'b0, 19'h00001, 8'h00);

        // Random mix over a small address pool
        for (int i = 0; i < 200; i++) begin
            logic [18:0] a;
            a = 19'(($urandom % 16) * 19'h08421);
            issue(1'($urandom % 2), a, 8'($urandom));
            if ($urandom % 5 == 0) repeat ($urandom % 3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        report();
    end

endmodule